// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block keeps one free-running 64-bit time count and one 64-bit compare value for each of a configurable number of harts. Each hart gets its own timer interrupt line. That line is high while the hart's compare value is less than or equal to the current time. Because the test is a level comparison, a compare value that is already in the past raises the line straight away. A future value holds the line low until time catches up.

Software reaches the block over a plain 32-bit register bus. Each 64-bit value is seen as two 32-bit halves, and the halves sit in little-endian order. Compare values live in 8-byte slots starting at a parameterised compare base. Slot `i` drives `irq[i]`. The time value is read at a parameterised time base and cannot be written.

The bus has no back-pressure. Every request is accepted in the cycle `bus_valid` is high. A read answers with `rd_valid` and `rd_data` exactly one cycle later. Time advances only on cycles where `tick_en` is high, so the tick source is any enable pulse already in the clock domain.

Top module: `mtc_timer`

## Requirements
- R1: The time count resets to 0. It rises by exactly one on each clock edge where `tick_en` is high, holds otherwise, and wraps from all ones to zero.
- R2: Compare slot `i` (0 ≤ i < NUM_HARTS) lives at address CMP_BASE + 8·i. Offset +0 of the slot holds bits 31:0 and offset +4 holds bits 63:32.
- R3: A write to the low half of a slot replaces bits 31:0 and keeps bits 63:32. A write to the high half replaces bits 63:32 and keeps bits 31:0.
- R4: `irq[i]` is registered. One cycle after any change of time or compare, it equals (compare_i ≤ time) as an unsigned 64-bit test. A past or equal value therefore asserts it, and a future value deasserts it.
- R5: A read at TIME_BASE returns time bits 31:0. A read at TIME_BASE + 4 returns time bits 63:32.
- R6: Writes to TIME_BASE or TIME_BASE + 4 leave the time count unchanged.
- R7: Every compare value resets to 0. While reset is held, `irq` and `rd_valid` are 0.
- R8: Reads of any address that is not a compare half or a time half return 0, including sub-offsets other than +0 and +4 inside a slot. Writes to such addresses change no compare value.
- R9: `rd_valid` is high for exactly the one cycle after a read request (`bus_valid` high, `bus_write` low). It is low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advance time by one on this edge |
| bus_valid | input | 1 | Register request present, always accepted |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| irq | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The hardest case to reach from the ports is the exact boundary where a compare value equals the time. The same boundary matters when a compare value differs from time only in its upper half. Time is read-only and runs on its own, so the bench holds `tick_en` low to freeze it and tracks the count it has issued. It then writes compare values a known distance ahead, steps time one tick at a time across equality, and uses high-half writes to move a compare value past 2^32 and back.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned TIME_W = 64;

  typedef logic [TIME_W-1:0] tval_t;
  typedef logic [BUS_W-1:0]  word_t;

  // Rebuild a 64-bit value from one new 32-bit half, keeping the other half.
  function automatic tval_t merge_half(tval_t old_v, word_t wd, logic upper);
    return upper ? {wd, old_v[BUS_W-1:0]} : {old_v[TIME_W-1:BUS_W], wd};
  endfunction
endpackage

// File: rtl/mtc_time_counter.sv
module mtc_time_counter
  import mtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_en,
  output tval_t time_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)       time_q <= '0;
    else if (tick_en) time_q <= time_q + tval_t'(1);
  end
endmodule

// File: rtl/mtc_cmp_slot.sv
module mtc_cmp_slot
  import mtc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_lo,
  input  logic  wr_hi,
  input  word_t wdata,
  input  tval_t time_now,
  output tval_t cmp_q,
  output logic  irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_lo)      cmp_q <= merge_half(cmp_q, wdata, 1'b0);
      else if (wr_hi) cmp_q <= merge_half(cmp_q, wdata, 1'b1);
      irq_q <= (cmp_q <= time_now);
    end
  end
endmodule

// File: rtl/mtc_decode.sv
module mtc_decode #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMP_BASE  = 'h0000,
  parameter int unsigned TIME_BASE = 'h7FF8
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_HARTS-1:0] hit_lo,
  output logic [NUM_HARTS-1:0] hit_hi,
  output logic                 hit_tlo,
  output logic                 hit_thi
);
  localparam logic [ADDR_W-1:0] T_LO = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] T_HI = ADDR_W'(TIME_BASE + 4);

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_slot
    localparam logic [ADDR_W-1:0] S_LO = ADDR_W'(CMP_BASE + 8 * g);
    localparam logic [ADDR_W-1:0] S_HI = ADDR_W'(CMP_BASE + 8 * g + 4);
    assign hit_lo[g] = (addr == S_LO);
    assign hit_hi[g] = (addr == S_HI);
  end

  assign hit_tlo = (addr == T_LO);
  assign hit_thi = (addr == T_HI);
endmodule

// File: rtl/mtc_timer.sv
module mtc_timer
  import mtc_pkg::*;
#(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMP_BASE  = 'h0000,
  parameter int unsigned TIME_BASE = 'h7FF8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 rd_valid,
  output logic [31:0]          rd_data,
  output logic [NUM_HARTS-1:0] irq
);
  localparam int unsigned FLAT_W = NUM_HARTS * TIME_W;

  tval_t                 time_now;
  tval_t                 cmp_all [NUM_HARTS];
  logic [FLAT_W-1:0]     cmp_flat;
  logic [NUM_HARTS-1:0]  hit_lo, hit_hi;
  logic                  hit_tlo, hit_thi;
  logic                  wr_req, rd_req;
  word_t                 rdata_n;

  assign wr_req = bus_valid &&  bus_write;
  assign rd_req = bus_valid && !bus_write;

  mtc_time_counter u_time (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .time_q  (time_now)
  );

  mtc_decode #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W),
    .CMP_BASE  (CMP_BASE),
    .TIME_BASE (TIME_BASE)
  ) u_dec (
    .addr    (bus_addr),
    .hit_lo  (hit_lo),
    .hit_hi  (hit_hi),
    .hit_tlo (hit_tlo),
    .hit_thi (hit_thi)
  );

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    mtc_cmp_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_req && hit_lo[g]),
      .wr_hi    (wr_req && hit_hi[g]),
      .wdata    (bus_wdata),
      .time_now (time_now),
      .cmp_q    (cmp_all[g]),
      .irq_q    (irq[g])
    );
    assign cmp_flat[g*TIME_W +: TIME_W] = cmp_all[g];
  end

  // One-hot hits OR together; an unmapped address selects nothing and yields 0.
  always_comb begin
    rdata_n = '0;
    for (int h = 0; h < NUM_HARTS; h++) begin
      if (hit_lo[h]) rdata_n = rdata_n | cmp_all[h][31:0];
      if (hit_hi[h]) rdata_n = rdata_n | cmp_all[h][63:32];
    end
    if (hit_tlo) rdata_n = rdata_n | time_now[31:0];
    if (hit_thi) rdata_n = rdata_n | time_now[63:32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? rdata_n : '0;
    end
  end
endmodule

// File: rtl/mtc_timer_chk.sv
module mtc_timer_chk #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CMP_BASE  = 'h0000
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tick_en,
  input logic                    bus_valid,
  input logic                    bus_write,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [31:0]             bus_wdata,
  input logic                    rd_valid,
  input logic [NUM_HARTS-1:0]    irq,
  input logic [63:0]             time_q,
  input logic [NUM_HARTS*64-1:0] cmp_flat
);
  AST_TIME_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> time_q == $past(time_q) + 64'd1); // R1
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> time_q == $past(time_q)); // R6
  AST_RD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> rd_valid); // R9
  AST_RD_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !rd_valid); // R9

  for (genvar g = 0; g < NUM_HARTS; g++) begin : g_hart
    localparam logic [ADDR_W-1:0] S_LO = ADDR_W'(CMP_BASE + 8 * g);
    localparam logic [ADDR_W-1:0] S_HI = ADDR_W'(CMP_BASE + 8 * g + 4);
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> irq[g] == ($past(cmp_flat[g*64 +: 64]) <= $past(time_q))); // R4
    AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == S_LO) |=>
        cmp_flat[g*64 +: 64] == {$past(cmp_flat[g*64+32 +: 32]), $past(bus_wdata)}); // R3
    AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_write && bus_addr == S_HI) |=>
        cmp_flat[g*64 +: 64] == {$past(bus_wdata), $past(cmp_flat[g*64 +: 32])}); // R3
  end
endmodule

bind mtc_timer mtc_timer_chk #(
  .NUM_HARTS (NUM_HARTS),
  .ADDR_W    (ADDR_W),
  .CMP_BASE  (CMP_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_en   (tick_en),
  .bus_valid (bus_valid),
  .bus_write (bus_write),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_valid  (rd_valid),
  .irq       (irq),
  .time_q    (time_now),
  .cmp_flat  (cmp_flat)
);

// File: tb/mtc_timer_bench.sv
module mtc_timer_bench;
  localparam int unsigned NH = 4;
  localparam int unsigned AW = 16;
  localparam int unsigned CB = 'h0000;
  localparam int unsigned TB = 'h7FF8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_en = 1'b0;
  logic          bus_valid = 1'b0;
  logic          bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic          rd_valid;
  logic [31:0]   rd_data;
  logic [NH-1:0] irq;

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_time = '0;
  logic [63:0] exp_cmp [NH];

  always #10 clk = ~clk;

  mtc_timer #(.NUM_HARTS(NH), .ADDR_W(AW), .CMP_BASE(CB), .TIME_BASE(TB)) u_mtc_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [NH-1:0] irq_model();
    logic [NH-1:0] v;
    for (int h = 0; h < NH; h++) v[h] = (exp_cmp[h] <= exp_time);
    return v;
  endfunction

  task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
    for (int h = 0; h < NH; h++) begin
      if (a == AW'(CB + 8*h))     exp_cmp[h][31:0]  = d;
      if (a == AW'(CB + 8*h + 4)) exp_cmp[h][63:32] = d;
    end
  endtask

  task automatic bus_rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check("R9 rd_valid after read", 64'(rd_valid), 64'd1);
    d = rd_data;
  endtask

  task automatic tick(int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    exp_time = exp_time + 64'(n);
  endtask

  task automatic check_irq(string req);
    @(negedge clk);
    check(req, 64'(irq), 64'(irq_model()));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int h = 0; h < NH; h++) exp_cmp[h] = '0;
    repeat (3) @(negedge clk);
    check("R7 irq low in reset", 64'(irq), 64'd0);
    check("R7 rd_valid low in reset", 64'(rd_valid), 64'd0);
    rst_n = 1'b1;
    check_irq("R7 zero compare asserts irq");
    for (int h = 0; h < NH; h++) begin
      bus_rd(AW'(CB + 8*h), d);     check("R7 cmp lo reset", 64'(d), 64'd0);
      bus_rd(AW'(CB + 8*h + 4), d); check("R7 cmp hi reset", 64'(d), 64'd0);
    end
  endtask

  task automatic t_time();
    logic [31:0] d;
    bus_rd(AW'(TB), d); check("R1 time reset zero", 64'(d), 64'd0);
    tick(10);
    bus_rd(AW'(TB), d);     check("R5 time lo", 64'(d), 64'(exp_time[31:0]));
    bus_rd(AW'(TB + 4), d); check("R5 time hi", 64'(d), 64'(exp_time[63:32]));
    tick(1);
    bus_rd(AW'(TB), d); check("R1 single tick", 64'(d), 64'(exp_time[31:0]));
  endtask

  task automatic t_halves();
    logic [31:0] d;
    bus_wr(AW'(CB + 8), 32'hDEADBEEF);
    bus_wr(AW'(CB + 12), 32'h00000001);
    bus_rd(AW'(CB + 8), d);  check("R3 lo after hi write", 64'(d), 64'hDEADBEEF);
    bus_wr(AW'(CB + 8), 32'h12345678);
    bus_rd(AW'(CB + 12), d); check("R3 hi kept on lo write", 64'(d), 64'h1);
    bus_rd(AW'(CB + 8), d);  check("R3 lo replaced", 64'(d), 64'h12345678);
    check_irq("R4 future compare low");
  endtask

  task automatic t_boundary();
    bus_wr(AW'(CB + 16), exp_time[31:0] + 32'd5);
    check_irq("R4 future value deasserts");
    tick(4);
    check_irq("R4 one below compare");
    tick(1);
    check_irq("R4 equal asserts");
    check("R4 hart2 high at equality", 64'(irq[2]), 64'd1);
    bus_wr(AW'(CB + 16), exp_time[31:0] + 32'd100);
    check_irq("R4 moved to future");
    bus_wr(AW'(CB + 16), 32'd3);
    check_irq("R4 past value asserts at once");
    check("R4 hart2 high for past", 64'(irq[2]), 64'd1);
  endtask

  task automatic t_upper();
    bus_wr(AW'(CB + 28), 32'h00000001);
    check_irq("R4 high half puts compare ahead");
    check("R4 hart3 low", 64'(irq[3]), 64'd0);
    bus_wr(AW'(CB + 28), 32'h00000000);
    check_irq("R4 high half cleared");
    check("R4 hart3 high", 64'(irq[3]), 64'd1);
  endtask

  task automatic t_time_ro();
    logic [31:0] d;
    bus_wr(AW'(TB), 32'hFFFFFFFF);
    bus_wr(AW'(TB + 4), 32'hFFFFFFFF);
    bus_rd(AW'(TB), d);     check("R6 time lo unchanged", 64'(d), 64'(exp_time[31:0]));
    bus_rd(AW'(TB + 4), d); check("R6 time hi unchanged", 64'(d), 64'(exp_time[63:32]));
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(AW'(CB), 32'hA5A5A5A5);
    bus_rd(AW'(CB + 2), d);  check("R8 sub-offset reads zero", 64'(d), 64'd0);
    bus_rd(AW'(CB + 1), d);  check("R8 odd offset reads zero", 64'(d), 64'd0);
    bus_rd(AW'('h0100), d);  check("R8 gap reads zero", 64'(d), 64'd0);
    bus_wr(AW'(CB + 2), 32'hFFFFFFFF);
    bus_wr(AW'(CB + 8*NH), 32'hFFFFFFFF);
    bus_rd(AW'(CB), d);      check("R8 slot0 lo untouched", 64'(d), 64'hA5A5A5A5);
    bus_rd(AW'(CB + 4), d);  check("R8 slot0 hi untouched", 64'(d), 64'd0);
    check_irq("R8 irqs untouched by stray writes");
  endtask

  task automatic t_map();
    logic [31:0] d;
    for (int h = 0; h < NH; h++) bus_wr(AW'(CB + 8*h + 4), 32'h10 + 32'(h));
    for (int h = 0; h < NH; h++) begin
      bus_rd(AW'(CB + 8*h + 4), d);
      check("R2 slot hi mapping", 64'(d), 64'h10 + 64'(h));
    end
    check_irq("R2 all compares ahead");
  endtask

  task automatic t_rd_valid();
    bus_wr(AW'(CB), 32'h0);
    check("R9 no rd_valid after write", 64'(rd_valid), 64'd0);
    @(negedge clk);
    check("R9 no rd_valid when idle", 64'(rd_valid), 64'd0);
  endtask

  initial begin
    t_reset();
    t_time();
    t_halves();
    t_boundary();
    t_upper();
    t_time_ro();
    t_unmapped();
    t_map();
    t_rd_valid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule